// File: doc/BRIEF.md
# Status-Poll Completion Judge

After the host has issued a program or erase command to a flash device, this block decides whether the operation finished successfully. It reads the device status byte at a valid address, again and again. Each time it compares status bit 7 with the value that bit 7 of the target location should hold once the operation is done. When the two agree, the operation has completed and the block reports pass.

Status bit 5 is the device's time-limit flag. When bit 5 is set on a read whose bit 7 still disagrees, the block does not give up at once. Bit 7 may change on the same read as the flag, so the block makes exactly one further read and decides on that read's bit 7 alone.

A poll-count ceiling guarantees that a check always ends. The ceiling is a parameter, and a value of zero turns it off. The block keeps one read in flight at a time: the request stays high until it is acknowledged. The host supplies the address, so it chooses the valid location:
- the programmed word, for a program operation;
- an address in a selected sector, for a sector erase;
- an address in any unprotected sector, for a chip erase.

Top module: `poll_judge`

## Requirements
- R1: During and after reset, with no start received, done, pass, fail and rd_req are all low.
- R2: A start pulse while idle raises rd_req on the next cycle. The block captures exp_d7 at that point. rd_req then stays high until rd_ack is seen with it.
- R3: If an acknowledged read returns rd_data[7] equal to the captured expected bit, then on the next cycle done and pass are high, fail is low, and rd_req is low.
- R4: If an acknowledged read has rd_data[7] unequal to the expected bit and rd_data[5] = 0, and the poll ceiling is not reached, another read is requested at once and no done is produced.
- R5: If an acknowledged read has rd_data[7] unequal to the expected bit and rd_data[5] = 1, exactly one further read is made. The check passes if that read's bit 7 matches. The value of bit 5 on that read has no effect.
- R6: If that further read's bit 7 does not match, the check ends with done and fail high and pass low.
- R7: A read on which bit 7 matches and bit 5 is also 1 ends the check with pass immediately. No extra read is made.
- R8: done is high for exactly one cycle per check, and in that cycle exactly one of pass and fail is high. Neither pass nor fail is ever high without done.
- R9: With MAX_POLLS nonzero, after MAX_POLLS consecutive acknowledged reads that each have a bit-7 mismatch and bit 5 = 0, the check ends with fail on the next cycle.
- R10: A start pulse while a check is in progress has no effect. The number of reads and the outcome are unchanged, and no new check begins after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a completion check |
| exp_d7 | input | 1 | Expected final value of bit 7 at the polled location |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; rd_data valid in this cycle |
| rd_data | input | 8 | Returned status byte (bit 7 data, bit 5 time-limit flag) |
| done | output | 1 | One-cycle end-of-check pulse |
| pass | output | 1 | Operation completed, valid with done |
| fail | output | 1 | Operation failed or poll ceiling hit, valid with done |

## Verification
The bench sweeps both expected-bit polarities. For each, it tries every count of leading plain mismatches from zero to beyond the poll ceiling. Each count ends in one of four ways:
- a plain match, which shows a normal completion;
- a match coinciding with the flag, which shows R7's immediate pass against a needless extra read;
- a flag followed by a match, which shows the coincident-completion recovery;
- a flag followed by a mismatch, which shows a true failure.

Acknowledge latency varies from zero to two idle cycles, and start is held high throughout each busy period. Comparing the count of reads and the final outcome with arithmetic predictions separates the ceiling behaviour from the flag behaviour and exposes any restart caused by an ignored start.

// File: rtl/poll_judge.sv
module poll_judge #(
  parameter int MAX_POLLS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       exp_d7,
  output logic       rd_req,
  input  logic       rd_ack,
  input  logic [7:0] rd_data,
  output logic       done,
  output logic       pass,
  output logic       fail
);

  localparam int CW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);

  typedef enum logic [1:0] {IDLE, POLL, LAST} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          exp_q;

  wire hit      = rd_req && rd_ack;
  wire match    = rd_data[7] == exp_q;
  wire to_flag  = rd_data[5];
  wire at_limit = (MAX_POLLS != 0) && (cnt == CW'(MAX_POLLS - 1));

  assign rd_req = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      exp_q <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st    <= POLL;
          cnt   <= '0;
          exp_q <= exp_d7;
        end
        POLL: if (hit) begin
          if (match) begin
            st <= IDLE; done <= 1'b1; pass <= 1'b1;
          end else if (to_flag) begin
            st <= LAST;
          end else if (at_limit) begin
            st <= IDLE; done <= 1'b1; fail <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LAST: if (hit) begin
          st   <= IDLE;
          done <= 1'b1;
          pass <= match;
          fail <= !match;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r8_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done);
  a_r3_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_req && rd_ack));
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);
  a_r3_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

endmodule

// File: tb/poll_judge_bench.sv
module poll_judge_bench;
  localparam int MAXP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       exp_d7 = 1'b0;
  logic       rd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       rd_req, done, pass, fail;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  poll_judge #(.MAX_POLLS(MAXP)) u_poll_judge (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_d7(exp_d7),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .pass(pass), .fail(fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // kind: 0 plain match, 1 flag then match, 2 flag then mismatch, 3 match with flag
  function automatic logic [7:0] status(input bit e, input int n, input int kind, input int i);
    logic [7:0] v;
    v = 8'(i * 37) & 8'h5F;
    if (i < n) begin
      v[7] = ~e; v[5] = 1'b0;
    end else if (i == n) begin
      v[7] = (kind == 0 || kind == 3) ? e : ~e;
      v[5] = (kind != 0);
    end else begin
      v[7] = (kind == 1) ? e : ~e;
      v[5] = 1'b1;
    end
    return v;
  endfunction

  task automatic run(input bit e, input int n, input int kind, input int lat);
    int  exp_reads;
    bit  exp_pass;
    int  reads;
    bit  fin;
    if (n >= MAXP) begin
      exp_reads = MAXP; exp_pass = 1'b0;
    end else begin
      exp_reads = n + ((kind == 1 || kind == 2) ? 2 : 1);
      exp_pass  = (kind != 2);
    end
    @(negedge clk);
    exp_d7 = e; start = 1'b1;
    @(negedge clk);
    exp_d7 = ~e;
    chk(rd_req === 1'b1, "R2 req after start", int'(rd_req), 1);
    reads = 0; fin = 0;
    while (!fin && reads < 40) begin
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk(rd_req === 1'b1 && done === 1'b0, "R2 req held while waiting", int'(rd_req), 1);
      end
      rd_ack = 1'b1;
      rd_data = status(e, n, kind, reads);
      @(negedge clk);
      rd_ack = 1'b0;
      reads++;
      if (done === 1'b1) fin = 1;
      else chk(rd_req === 1'b1, "R4 next read requested", int'(rd_req), 1);
    end
    start = 1'b0;
    chk(reads == exp_reads, n >= MAXP ? "R9 reads before ceiling" :
        (kind == 3 ? "R7 reads" : (kind == 0 ? "R4 reads" : "R5 reads")), reads, exp_reads);
    chk(pass === exp_pass && fail === !exp_pass,
        n >= MAXP ? "R9 verdict" : (kind == 2 ? "R6 verdict" : (kind == 1 ? "R5 verdict" : "R3 verdict")),
        int'(pass), int'(exp_pass));
    chk(rd_req === 1'b0, "R3 req low at done", int'(rd_req), 0);
    @(negedge clk);
    chk(done === 1'b0 && pass === 1'b0 && fail === 1'b0, "R8 done single cycle", int'(done), 0);
    chk(rd_req === 1'b0, "R10 no restart from busy start", int'(rd_req), 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && pass === 1'b0 && fail === 1'b0 && rd_req === 1'b0,
        "R1 outputs in reset", int'(rd_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done === 1'b0 && rd_req === 1'b0, "R1 idle after reset", int'(rd_req), 0);
    for (int e = 0; e < 2; e++)
      for (int n = 0; n <= MAXP + 1; n++)
        for (int k = 0; k < 4; k++)
          for (int l = 0; l < 3; l++)
            run(e[0], n, k, l);
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule